// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles, once link negotiation has finished, which directions of pause-frame flow control the MAC should honour. It takes the pause capability bits that the local station advertised and the ones the link partner returned, together with the mode software asked for, a strict-standard switch and the link status flags. From these it produces a two-bit mode and the two enables that the MAC's transmit and receive paths consume.

Resolution is triggered by a one-cycle strobe. The strobe is sampled on a clock edge, and the resolved mode, the enables and the configuration-error flag are registered on that same edge. A done pulse lasting one cycle appears alongside them. Between strobes every output holds its value. When negotiation has failed, the requested mode is imposed directly. When negotiation is still pending, the previous result is kept.

The resolution follows the standard pause table, with two lenient fallbacks. First, a symmetric agreement is narrowed to receive-only unless software asked for full flow control. Second, a partner that offers no usable pause capability still leaves the local side receiving pause frames, unless strict mode is set or software asked for none or transmit-only.

Top module: `pause_fc_resolver`

## Requirements
- R1: The mode output uses the codes 0 = none, 1 = receive-only, 2 = transmit-only, 3 = both directions. The transmit enable is 1 exactly for codes 2 and 3, and the receive enable is 1 exactly for codes 1 and 3.
- R2: On a negotiated resolution where both the local and the partner pause bits are 1, the mode becomes 3 if the request is 3, and 1 for any other request value.
- R3: On a negotiated resolution with local pause 0 and local asymmetric 1, and partner pause 1 and partner asymmetric 1, the mode becomes 2.
- R4: On a negotiated resolution with local pause 1 and local asymmetric 1, and partner pause 0 and partner asymmetric 1, the mode becomes 1.
- R5: On a negotiated resolution matching none of the cases in R2 to R4, the mode becomes 0 when the request is 0 or 2 or when strict mode is 1. Otherwise it becomes 1, including for unused request codes 4 to 7.
- R6: On a negotiated resolution with the full-duplex input at 0, the mode becomes 0 regardless of the advertised bits.
- R7: On a strobe with the negotiation-failed input at 1 and a request from 0 to 3, the mode becomes the request value. The advertised bits, the strict flag and the duplex input have no effect.
- R8: On a strobe with negotiation failed and a request from 4 to 7, the configuration error becomes 1 and the mode and both enables keep their previous values. Any other strobe clears the configuration error.
- R9: On a strobe with negotiation neither failed nor complete, the mode and both enables keep their previous values.
- R10: Results of a strobe sampled on a clock edge appear right after that edge, together with done = 1 for exactly one cycle. Without a strobe, done is 0 and all outputs hold.
- R11: While reset is low, and after its release, the mode, both enables, done and the configuration error are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resolve_i | input | 1 | One-cycle request to resolve |
| an_done_i | input | 1 | Auto-negotiation has completed |
| an_fail_i | input | 1 | Auto-negotiation failed; link forced |
| full_dup_i | input | 1 | Link is full duplex |
| strict_i | input | 1 | Strict standard resolution, no lenient fallback |
| req_mode_i | input | REQ_W | Software-requested mode (codes 4 and up are illegal) |
| loc_pause_i | input | 1 | Local advertised symmetric pause bit |
| loc_asym_i | input | 1 | Local advertised asymmetric direction bit |
| lp_pause_i | input | 1 | Partner advertised symmetric pause bit |
| lp_asym_i | input | 1 | Partner advertised asymmetric direction bit |
| mode_o | output | 2 | Resolved mode |
| tx_fc_en_o | output | 1 | Enable sending pause frames |
| rx_fc_en_o | output | 1 | Enable acting on received pause frames |
| done_o | output | 1 | Resolution finished (one-cycle pulse) |
| cfg_err_o | output | 1 | Last strobe carried an illegal forced request |

## Verification
The bench targets a number of corner cases, and each has a distinct failure symptom:
- Request codes 4 to 7 on the negotiated path must fall into the lenient receive-only branch. A design that truncates the request to two bits would return none or full there.
- An illegal forced request must leave the enables untouched. A design that applies the truncated code would visibly change the mode.
- Half duplex must override even a symmetric agreement. The forced path, by contrast, must ignore duplex, so a design applying the duplex override too broadly would clear a forced mode.
- A strobe while negotiation is pending must still pulse done but change nothing, and it must clear a stale configuration error.

The bench also sweeps every combination of advertised bits, request, strict flag and duplex.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_RX   = 2'd1,
      FC_TX   = 2'd2,
      FC_FULL = 2'd3
   } fc_mode_e;

   typedef struct packed {
      logic sym;
      logic asym;
   } adv_bits_t;

endpackage

// File: rtl/pause_fc_request_check.sv
module pause_fc_request_check
   import pause_fc_pkg::*;
#(
   parameter int REQ_W = 3
) (
   input  logic [REQ_W-1:0] req_i,
   output logic             legal_o,
   output fc_mode_e         mode_o
);

   generate
      if (REQ_W < 2) begin : g_bad_width
         $error("pause_fc_request_check: REQ_W must be at least 2");
      end
      if (REQ_W > 2) begin : g_wide
         assign legal_o = ~|req_i[REQ_W-1:2];
      end else begin : g_narrow
         assign legal_o = 1'b1;
      end
   endgenerate

   assign mode_o = fc_mode_e'(req_i[1:0]);

endmodule

// File: rtl/pause_fc_negotiate.sv
module pause_fc_negotiate
   import pause_fc_pkg::*;
#(
   parameter int REQ_W = 3
) (
   input  adv_bits_t        loc_i,
   input  adv_bits_t        lp_i,
   input  logic [REQ_W-1:0] req_i,
   input  logic             strict_i,
   input  logic             full_dup_i,
   output fc_mode_e         mode_o
);

   localparam logic [REQ_W-1:0] REQ_NONE = REQ_W'(0);
   localparam logic [REQ_W-1:0] REQ_TX   = REQ_W'(2);
   localparam logic [REQ_W-1:0] REQ_FULL = REQ_W'(3);

   logic     want_full;
   logic     want_quiet;
   logic     sym_both;
   logic     tx_only_case;
   logic     rx_only_case;
   fc_mode_e table_mode;

   assign want_full    = (req_i == REQ_FULL);
   assign want_quiet   = (req_i == REQ_NONE) || (req_i == REQ_TX) || strict_i;
   assign sym_both     = loc_i.sym & lp_i.sym;
   assign tx_only_case = ~loc_i.sym & loc_i.asym & lp_i.sym & lp_i.asym;
   assign rx_only_case = loc_i.sym & loc_i.asym & ~lp_i.sym & lp_i.asym;

   always_comb begin
      if (sym_both) begin
         table_mode = want_full ? FC_FULL : FC_RX;
      end else if (tx_only_case) begin
         table_mode = FC_TX;
      end else if (rx_only_case) begin
         table_mode = FC_RX;
      end else if (want_quiet) begin
         table_mode = FC_NONE;
      end else begin
         table_mode = FC_RX;
      end
   end

   assign mode_o = full_dup_i ? table_mode : FC_NONE;

endmodule

// File: rtl/pause_fc_enable_decode.sv
module pause_fc_enable_decode
   import pause_fc_pkg::*;
(
   input  fc_mode_e mode_i,
   output logic     tx_en_o,
   output logic     rx_en_o
);

   always_comb begin
      unique case (mode_i)
         FC_NONE: begin tx_en_o = 1'b0; rx_en_o = 1'b0; end
         FC_RX:   begin tx_en_o = 1'b0; rx_en_o = 1'b1; end
         FC_TX:   begin tx_en_o = 1'b1; rx_en_o = 1'b0; end
         default: begin tx_en_o = 1'b1; rx_en_o = 1'b1; end
      endcase
   end

endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
   import pause_fc_pkg::*;
#(
   parameter int REQ_W       = 3,
   parameter bit REG_ENABLES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resolve_i,
   input  logic             an_done_i,
   input  logic             an_fail_i,
   input  logic             full_dup_i,
   input  logic             strict_i,
   input  logic [REQ_W-1:0] req_mode_i,
   input  logic             loc_pause_i,
   input  logic             loc_asym_i,
   input  logic             lp_pause_i,
   input  logic             lp_asym_i,
   output logic [1:0]       mode_o,
   output logic             tx_fc_en_o,
   output logic             rx_fc_en_o,
   output logic             done_o,
   output logic             cfg_err_o
);

   localparam logic [REQ_W-1:0] REQ_TOP_LEGAL = REQ_W'(3);

   generate
      if (REQ_W < 2) begin : g_bad_req_w
         $error("pause_fc_resolver: REQ_W must be at least 2");
      end
   endgenerate

   adv_bits_t loc_adv;
   adv_bits_t lp_adv;
   fc_mode_e  neg_mode;
   fc_mode_e  req_mode;
   logic      req_legal;
   fc_mode_e  mode_q;
   fc_mode_e  mode_nxt;
   logic      mode_load;
   logic      err_nxt;
   logic      done_q;
   logic      err_q;

   assign loc_adv = '{sym: loc_pause_i, asym: loc_asym_i};
   assign lp_adv  = '{sym: lp_pause_i,  asym: lp_asym_i};

   pause_fc_negotiate #(.REQ_W(REQ_W)) u_negotiate (
      .loc_i      (loc_adv),
      .lp_i       (lp_adv),
      .req_i      (req_mode_i),
      .strict_i   (strict_i),
      .full_dup_i (full_dup_i),
      .mode_o     (neg_mode)
   );

   pause_fc_request_check #(.REQ_W(REQ_W)) u_req_check (
      .req_i   (req_mode_i),
      .legal_o (req_legal),
      .mode_o  (req_mode)
   );

   // Select the source of the next mode; forced link wins over negotiation.
   always_comb begin
      mode_nxt  = mode_q;
      mode_load = 1'b0;
      err_nxt   = 1'b0;
      if (an_fail_i) begin
         err_nxt = ~req_legal;
         if (req_legal) begin
            mode_nxt  = req_mode;
            mode_load = 1'b1;
         end
      end else if (an_done_i) begin
         mode_nxt  = neg_mode;
         mode_load = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= FC_NONE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= resolve_i;
         if (resolve_i) begin
            err_q <= err_nxt;
            if (mode_load) begin
               mode_q <= mode_nxt;
            end
         end
      end
   end

   generate
      if (REG_ENABLES) begin : g_reg_en
         logic tx_d, rx_d, tx_q, rx_q;
         pause_fc_enable_decode u_dec (
            .mode_i  (mode_nxt),
            .tx_en_o (tx_d),
            .rx_en_o (rx_d)
         );
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_q <= 1'b0;
               rx_q <= 1'b0;
            end else if (resolve_i && mode_load) begin
               tx_q <= tx_d;
               rx_q <= rx_d;
            end
         end
         assign tx_fc_en_o = tx_q;
         assign rx_fc_en_o = rx_q;
      end else begin : g_comb_en
         pause_fc_enable_decode u_dec (
            .mode_i  (mode_q),
            .tx_en_o (tx_fc_en_o),
            .rx_en_o (rx_fc_en_o)
         );
      end
   endgenerate

   assign mode_o    = mode_q;
   assign done_o    = done_q;
   assign cfg_err_o = err_q;

   AST_TX_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fc_en_o == (mode_o == 2'd2 || mode_o == 2'd3)); // R1
   AST_RX_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fc_en_o == (mode_o == 2'd1 || mode_o == 2'd3)); // R1
   AST_HALF_DUPLEX_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_i && !an_fail_i && an_done_i && !full_dup_i |=> mode_o == 2'd0); // R6
   AST_FORCED_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_i && an_fail_i && req_mode_i <= REQ_TOP_LEGAL
      |=> mode_o == $past(req_mode_i[1:0])); // R7
   AST_BAD_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_i && an_fail_i && req_mode_i > REQ_TOP_LEGAL
      |=> cfg_err_o && $stable(mode_o) && $stable(tx_fc_en_o) && $stable(rx_fc_en_o)); // R8
   AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_i && !an_fail_i && !an_done_i |=> $stable(mode_o) && !cfg_err_o); // R9
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_i |=> done_o); // R10
   AST_DONE_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      !resolve_i |=> !done_o && $stable(mode_o) && $stable(cfg_err_o)); // R10

endmodule

// File: tb/test_pause_fc_resolver.sv
`timescale 1ns/1ps
module test_pause_fc_resolver;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       resolve = 1'b0, an_done = 1'b0, an_fail = 1'b0;
   logic       full_dup = 1'b1, strict = 1'b0;
   logic [2:0] req = 3'd0;
   logic       lps = 1'b0, lpa = 1'b0, ps = 1'b0, pa = 1'b0;
   logic [1:0] mode;
   logic       tx_en, rx_en, done, err;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // behavioural reference state
   int    m_mode = 0;
   int    m_done = 0;
   int    m_err  = 0;
   string m_tag  = "R11";

   always #10 clk = ~clk;

   pause_fc_resolver i_pause_fc_resolver (
      .clk(clk), .rst_n(rst_n), .resolve_i(resolve), .an_done_i(an_done),
      .an_fail_i(an_fail), .full_dup_i(full_dup), .strict_i(strict),
      .req_mode_i(req), .loc_pause_i(lps), .loc_asym_i(lpa),
      .lp_pause_i(ps), .lp_asym_i(pa), .mode_o(mode), .tx_fc_en_o(tx_en),
      .rx_fc_en_o(rx_en), .done_o(done), .cfg_err_o(err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_done = 0; m_err = 0; m_tag = "R11";
      end else begin
         m_done = resolve;
         if (resolve) begin
            m_err = 0;
            if (an_fail) begin
               if (req > 3) begin m_err = 1; m_tag = "R8"; end
               else begin m_mode = int'(req); m_tag = "R7"; end
            end else if (an_done) begin
               if (!full_dup) begin m_mode = 0; m_tag = "R6"; end
               else if (lps && ps) begin m_mode = (req == 3) ? 3 : 1; m_tag = "R2"; end
               else if (!lps && lpa && ps && pa) begin m_mode = 2; m_tag = "R3"; end
               else if (lps && lpa && !ps && pa) begin m_mode = 1; m_tag = "R4"; end
               else begin
                  m_mode = (strict || req == 0 || req == 2) ? 0 : 1;
                  m_tag = "R5";
               end
            end else m_tag = "R9";
         end else m_tag = "R10";
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         chk(m_tag, int'(mode), m_mode);
         chk("R1", int'(tx_en), (m_mode >= 2) ? 1 : 0);
         chk("R1", int'(rx_en), m_mode % 2);
         chk("R10", int'(done), m_done);
         chk(m_tag, int'(err), m_err);
      end
   end

   task automatic fire(input logic f, input logic d, input logic fd, input logic st,
                       input logic [2:0] rq, input logic a, input logic b,
                       input logic c, input logic e);
      @(negedge clk);
      an_fail = f; an_done = d; full_dup = fd; strict = st; req = rq;
      lps = a; lpa = b; ps = c; pa = e; resolve = 1'b1;
      @(negedge clk);
      resolve = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", int'(mode), 0);
      chk("R11", int'(tx_en) + int'(rx_en) + int'(done) + int'(err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", int'(mode), 0);

      fire(0, 1, 1, 0, 3'd3, 1, 0, 1, 0);
      chk("R2", int'(mode), 3);
      chk("R1", int'(tx_en) * 2 + int'(rx_en), 3);
      chk("R10", int'(done), 1);
      @(negedge clk);
      chk("R10", int'(done), 0);
      chk("R10", int'(mode), 3);

      fire(0, 1, 1, 0, 3'd1, 1, 1, 1, 1);
      chk("R2", int'(mode), 1);
      fire(0, 1, 1, 0, 3'd3, 0, 1, 1, 1);
      chk("R3", int'(mode), 2);
      chk("R1", int'(tx_en) * 2 + int'(rx_en), 2);
      fire(0, 1, 1, 0, 3'd0, 1, 1, 0, 1);
      chk("R4", int'(mode), 1);
      fire(0, 1, 1, 1, 3'd3, 1, 0, 0, 0);
      chk("R5", int'(mode), 0);
      fire(0, 1, 1, 0, 3'd3, 1, 0, 0, 0);
      chk("R5", int'(mode), 1);
      fire(0, 1, 1, 0, 3'd2, 0, 0, 0, 0);
      chk("R5", int'(mode), 0);
      fire(0, 1, 1, 0, 3'd6, 0, 0, 0, 0);
      chk("R5", int'(mode), 1);
      fire(0, 1, 0, 0, 3'd3, 1, 1, 1, 1);
      chk("R6", int'(mode), 0);
      fire(1, 0, 0, 1, 3'd2, 1, 1, 1, 1);
      chk("R7", int'(mode), 2);
      fire(1, 1, 1, 0, 3'd5, 1, 1, 1, 1);
      chk("R8", int'(err), 1);
      chk("R8", int'(mode), 2);
      chk("R8", int'(tx_en) * 2 + int'(rx_en), 2);
      fire(0, 0, 1, 0, 3'd3, 1, 1, 1, 1);
      chk("R9", int'(mode), 2);
      chk("R8", int'(err), 0);

      for (int v = 0; v < 512; v++) begin
         fire(1'b0, 1'b1, v[0], v[1], v[4:2], v[5], v[6], v[7], v[8]);
      end
      for (int v = 0; v < 64; v++) begin
         fire(v[0], v[1], v[2], 1'b0, v[5:3], 1'b1, 1'b0, 1'b1, 1'b1);
      end

      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R11", int'(mode), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule